// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block holds the tags and data of a 16 kB, 4-way set-associative level-one data cache with 64-byte lines. It finds a set using only address bits that lie inside a 4 kB page. Those bits are the same before and after address translation, so the block can read the set while an external translation unit works out the physical page number. Each way therefore covers exactly one page of data. Because the stored tags are physical, the same physical line cannot sit in two different sets under two virtual names.

A lookup takes two cycles.
- In the request cycle the block captures the word-aligned page offset. At the next clock edge it reads the valid bits, the tags and the addressed word of all four ways in the chosen set.
- In the following cycle the translation port supplies the physical page number. All four stored tags are compared against it at the same time. The block then drives hit or miss, a one-hot hit way and the read word.

Two write paths feed the storage:
- A refill port writes a whole line into a victim way. The victim is the lowest-numbered invalid way if one exists; otherwise it comes from a per-set tree pseudo-LRU.
- A word-write port updates one word of a named way.

An invalidate-all input clears every valid bit in one cycle, and reset does the same. If more than one way matches in a single lookup, an error output is raised.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, with no refill since, `rsp_valid` is 0 when no lookup is in flight, and every lookup misses.
- R2: A request with `req_valid` high in one cycle gives `rsp_valid` high in exactly the next cycle, and low in any cycle whose preceding cycle had no request. `req_off` carries page-offset bits [11:2]: set index = `req_off[9:4]` (address bits [11:6]) and word in line = `req_off[3:0]` (address bits [5:2]).
- R3: In the response cycle, if a valid way of the set holds a tag equal to `xlat_ppn`, then `rsp_hit` is 1. Bit w of `rsp_way` is set for matching way w, and `rsp_data` is the addressed 32-bit word of that way.
- R4: In a response cycle with no matching valid way, `rsp_hit` is 0, `rsp_way` is 4'b0000 and `rsp_data` is 0.
- R5: A refill (`fill_valid`) writes `fill_line` into set `fill_set` with tag `fill_ppn` and marks the way valid. Word i of the line is `fill_line[32*i+31:32*i]`. If the set has an invalid way, the lowest-numbered invalid way is used.
- R6: When all four ways of the set are valid, the victim follows a 3-bit tree pseudo-LRU per set that is updated on every single-way lookup hit and every refill. On each such access, the root bit is set to 1 if way 0 or 1 was touched and to 0 otherwise. The pair bit for ways 0/1 is set to 1 if way 0 was touched and to 0 if way 1 was touched. The pair bit for ways 2/3 is set to 1 if way 2 was touched and to 0 if way 3 was touched. For victim choice, root 0 selects the 0/1 pair (way 1 if its pair bit is 1, else way 0), and root 1 selects the 2/3 pair (way 3 if its pair bit is 1, else way 2).
- R7: A word write (`wr_valid`) replaces only word `wr_off[3:0]` of way `wr_way` (binary index) in set `wr_off[9:4]`, leaving the other words of the line unchanged.
- R8: `multi_hit_err` is 1 in a response cycle where two or more valid ways match `xlat_ppn`; then `rsp_way` shows every matching way. It is 0 otherwise.
- R9: A cycle with `inval_all` high clears every valid bit. Lookups requested in that cycle or later miss until the line is refilled, and the next refill of a set goes to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Lookup request in this cycle |
| req_off | input | 10 | Page-offset address bits [11:2] of the lookup |
| xlat_ppn | input | 20 | Physical page number, valid in the response cycle |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Matching ways, one bit per way |
| rsp_data | output | 32 | Read word (0 on miss) |
| multi_hit_err | output | 1 | More than one way matched |
| fill_valid | input | 1 | Refill a line |
| fill_set | input | 6 | Set index of the refill |
| fill_ppn | input | 20 | Physical tag of the refilled line |
| fill_line | input | 512 | Line data, word i in bits [32i+31:32i] |
| wr_valid | input | 1 | Word write |
| wr_way | input | 2 | Way index of the word write |
| wr_off | input | 10 | Page-offset address bits [11:2] of the word write |
| wr_data | input | 32 | Word to write |

## Verification
Lookups are issued against an empty cache, against a partly filled set, and against a full set. The empty and partly filled cases show that an invalid way never hits and that refills take the lowest free way. The full-set case separates the tree victim choice from a plain round-robin or fixed choice. The same physical page is looked up in a neighbouring set and with a wrong page number, which shows that the index comes from offset bits and that the physical tag decides the hit. A duplicate refill of one line shows the multi-match flag. Word writes followed by reads of the neighbouring word, and lookups made after an invalidate, show that nothing else in the line or set is touched.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int WAYS       = 4;
    localparam int SETS       = 64;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BITS  = 32;
    localparam int PAGE_BITS  = 12;
    localparam int PA_BITS    = 32;

    localparam int OFF_BITS   = $clog2(LINE_BYTES);
    localparam int IDX_BITS   = $clog2(SETS);
    localparam int BSEL_BITS  = $clog2(WORD_BITS / 8);
    localparam int WSEL_BITS  = OFF_BITS - BSEL_BITS;
    localparam int TAG_BITS   = PA_BITS - PAGE_BITS;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int WAY_BITS   = $clog2(WAYS);
    localparam int WOFF_BITS  = PAGE_BITS - BSEL_BITS;

    typedef logic [TAG_BITS-1:0]  tag_t;
    typedef logic [IDX_BITS-1:0]  idx_t;
    typedef logic [WSEL_BITS-1:0] wsel_t;
    typedef logic [WAYS-1:0]      wayvec_t;
    typedef logic [WAY_BITS-1:0]  wayid_t;
    typedef logic [WAYS-2:0]      plru_t;   // [0] root, [1] pair 0/1, [2] pair 2/3
    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [LINE_BITS-1:0] line_t;
    typedef logic [WOFF_BITS-1:0] woff_t;

    typedef struct packed {
        idx_t  idx;
        wsel_t wsel;
    } loc_t;

    function automatic loc_t split_off(woff_t o);
        loc_t l;
        l.idx  = o[WOFF_BITS-1:WSEL_BITS];
        l.wsel = o[WSEL_BITS-1:0];
        return l;
    endfunction

    function automatic wayid_t low_way(wayvec_t v);
        wayid_t id = '0;
        for (int i = WAYS - 1; i >= 0; i--)
            if (v[i]) id = wayid_t'(i);
        return id;
    endfunction

    function automatic int popc(wayvec_t v);
        int n = 0;
        for (int i = 0; i < WAYS; i++)
            n += int'(v[i]);
        return n;
    endfunction

    // Tree update: point every node on the path away from the touched way.
    function automatic plru_t plru_touch(plru_t s, wayid_t w);
        plru_t r = s;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction

    function automatic wayid_t pick_victim(plru_t s, wayvec_t vld);
        if (~vld != '0)
            return low_way(~vld);
        else if (!s[0])
            return {1'b0, s[1]};
        else
            return {1'b1, s[2]};
    endfunction
endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array
    import vipt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    inval_all,
    input  logic    rd_en,
    input  idx_t    rd_idx,
    output wayvec_t rd_valid,
    output tag_t [WAYS-1:0] rd_tag,
    input  logic    fill_en,
    input  idx_t    fill_idx,
    input  wayid_t  fill_way,
    input  tag_t    fill_tag,
    output wayvec_t fill_set_valid
);
    wayvec_t valid_q [SETS];
    tag_t    tag_q   [WAYS][SETS];
    logic    any_valid;

    always_ff @(posedge clk) begin
        if (rst || inval_all) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
        end
        if (fill_en) tag_q[fill_way][fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
        end else if (rd_en) begin
            rd_valid <= inval_all ? '0 : valid_q[rd_idx];
            for (int w = 0; w < WAYS; w++) rd_tag[w] <= tag_q[w][rd_idx];
        end
    end

    assign fill_set_valid = valid_q[fill_idx];

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid |= (valid_q[s] != '0);
    end

    // R9: one cycle of invalidate leaves no valid way anywhere
    p_inval_clears_r9: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !any_valid);

    // R5: the refilled way is valid afterwards
    p_fill_marks_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !inval_all) |=> valid_q[$past(fill_idx)][$past(fill_way)]);
endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array
    import vipt_pkg::*;
(
    input  logic   clk,
    input  logic   rd_en,
    input  loc_t   rd_loc,
    output word_t [WAYS-1:0] rd_word,
    input  logic   fill_en,
    input  idx_t   fill_idx,
    input  wayid_t fill_way,
    input  line_t  fill_line,
    input  logic   wr_en,
    input  wayid_t wr_way,
    input  loc_t   wr_loc,
    input  word_t  wr_data
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        line_t mem [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == wayid_t'(w))
                mem[fill_idx] <= fill_line;
            else if (wr_en && wr_way == wayid_t'(w))
                mem[wr_loc.idx][wr_loc.wsel*WORD_BITS +: WORD_BITS] <= wr_data;
            if (rd_en)
                rd_word[w] <= mem[rd_loc.idx][rd_loc.wsel*WORD_BITS +: WORD_BITS];
        end
    end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
    import vipt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hit_en,
    input  idx_t    hit_idx,
    input  wayid_t  hit_way,
    input  logic    fill_en,
    input  idx_t    fill_idx,
    input  wayvec_t fill_set_valid,
    output wayid_t  victim
);
    plru_t state_q [SETS];

    assign victim = pick_victim(state_q[fill_idx], fill_set_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) state_q[s] <= '0;
        end else begin
            if (hit_en)  state_q[hit_idx]  <= plru_touch(state_q[hit_idx], hit_way);
            if (fill_en) state_q[fill_idx] <= plru_touch(state_q[fill_idx], victim);
        end
    end

    // R5: with a free way in the set, the victim is never a valid way
    p_victim_free_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_set_valid != '1) |-> !fill_set_valid[victim]);
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inval_all,
    input  logic                  req_valid,
    input  logic [WOFF_BITS-1:0]  req_off,
    input  logic [TAG_BITS-1:0]   xlat_ppn,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [WAYS-1:0]       rsp_way,
    output logic [WORD_BITS-1:0]  rsp_data,
    output logic                  multi_hit_err,
    input  logic                  fill_valid,
    input  logic [IDX_BITS-1:0]   fill_set,
    input  logic [TAG_BITS-1:0]   fill_ppn,
    input  logic [LINE_BITS-1:0]  fill_line,
    input  logic                  wr_valid,
    input  logic [WAY_BITS-1:0]   wr_way,
    input  logic [WOFF_BITS-1:0]  wr_off,
    input  logic [WORD_BITS-1:0]  wr_data
);
    loc_t    req_loc, wr_loc;
    logic    s2_vld;
    idx_t    s2_idx;
    wayvec_t s2_valid, match;
    tag_t  [WAYS-1:0] s2_tag;
    word_t [WAYS-1:0] s2_word;
    wayvec_t set_valid;
    wayid_t  victim;
    word_t   data_or;
    logic    single_hit;

    assign req_loc = split_off(req_off);
    assign wr_loc  = split_off(wr_off);

    // Stage 1: index with untranslated offset bits only.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_idx <= '0;
        end else begin
            s2_vld <= req_valid;
            if (req_valid) s2_idx <= req_loc.idx;
        end
    end

    vipt_tag_array u_tags (
        .clk(clk), .rst(rst), .inval_all(inval_all),
        .rd_en(req_valid), .rd_idx(req_loc.idx),
        .rd_valid(s2_valid), .rd_tag(s2_tag),
        .fill_en(fill_valid), .fill_idx(fill_set), .fill_way(victim),
        .fill_tag(fill_ppn), .fill_set_valid(set_valid)
    );

    vipt_data_array u_data (
        .clk(clk), .rd_en(req_valid), .rd_loc(req_loc), .rd_word(s2_word),
        .fill_en(fill_valid), .fill_idx(fill_set), .fill_way(victim),
        .fill_line(fill_line),
        .wr_en(wr_valid), .wr_way(wr_way), .wr_loc(wr_loc), .wr_data(wr_data)
    );

    vipt_plru u_plru (
        .clk(clk), .rst(rst),
        .hit_en(single_hit), .hit_idx(s2_idx), .hit_way(low_way(match)),
        .fill_en(fill_valid), .fill_idx(fill_set),
        .fill_set_valid(set_valid), .victim(victim)
    );

    // Stage 2: compare all physical tags in parallel once translation is in.
    always_comb begin
        data_or = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = s2_vld && s2_valid[w] && (s2_tag[w] == xlat_ppn);
            if (match[w]) data_or |= s2_word[w];
        end
    end

    assign rsp_valid     = s2_vld;
    assign rsp_way       = match;
    assign rsp_hit       = (match != '0);
    assign rsp_data      = data_or;
    assign multi_hit_err = (popc(match) > 1);
    assign single_hit    = rsp_hit && !multi_hit_err;

    // R2: response exactly one cycle after each request
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !inval_all) |=> rsp_valid);
    p_no_rsp_unasked_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3: without the error flag at most one way reports a hit
    p_single_way_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !multi_hit_err) |-> $onehot0(rsp_way));

    // R4: a miss drives neither a way nor data
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0 && rsp_data == '0));

    // R8: the error only rises on a response that hit
    p_err_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
        multi_hit_err |-> (rsp_valid && rsp_hit));
endmodule

// File: tb/tb_vipt_l1_lookup.sv
module tb_vipt_l1_lookup;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inval_all = 1'b0;
    logic         req_valid = 1'b0;
    logic [9:0]   req_off = '0;
    logic [19:0]  xlat_ppn = '0;
    logic         rsp_valid, rsp_hit, multi_hit_err;
    logic [3:0]   rsp_way;
    logic [31:0]  rsp_data;
    logic         fill_valid = 1'b0;
    logic [5:0]   fill_set = '0;
    logic [19:0]  fill_ppn = '0;
    logic [511:0] fill_line = '0;
    logic         wr_valid = 1'b0;
    logic [1:0]   wr_way = '0;
    logic [9:0]   wr_off = '0;
    logic [31:0]  wr_data = '0;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    vipt_l1_lookup dut (
        .clk(clk), .rst(rst), .inval_all(inval_all),
        .req_valid(req_valid), .req_off(req_off), .xlat_ppn(xlat_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data), .multi_hit_err(multi_hit_err),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_ppn(fill_ppn),
        .fill_line(fill_line),
        .wr_valid(wr_valid), .wr_way(wr_way), .wr_off(wr_off), .wr_data(wr_data)
    );

    localparam logic [19:0] PA = 20'hA1234, PB = 20'hB2345, PC = 20'hC3456,
                            PD = 20'hD4567, PE = 20'hE5678, PF = 20'hF6789,
                            PG = 20'h1789A, PH = 20'h289AB;

    function automatic logic [31:0] pat(logic [19:0] ppn, int idx, int w);
        return {ppn[15:0], 2'b10, idx[5:0], 4'h5, w[3:0]};
    endfunction

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic fill(int idx, logic [19:0] ppn);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_set = idx[5:0];
        fill_ppn = ppn;
        for (int i = 0; i < 16; i++) fill_line[i*32 +: 32] = pat(ppn, idx, i);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(string rq, int idx, int w, logic [19:0] ppn,
                          logic [3:0] exp_way, logic [31:0] exp_data, bit exp_err);
        @(negedge clk);
        req_valid = 1'b1;
        req_off = {idx[5:0], w[3:0]};
        @(negedge clk);
        req_valid = 1'b0;
        xlat_ppn = ppn;
        #5;
        check(rq, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rq, "rsp_hit", 32'(rsp_hit), 32'(exp_way != 4'd0));
        check(rq, "rsp_way", 32'(rsp_way), 32'(exp_way));
        check(rq, "rsp_data", rsp_data, exp_data);
        check(rq, "multi_hit_err", 32'(multi_hit_err), 32'(exp_err));
    endtask

    task automatic word_write(int way, int idx, int w, logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_way = way[1:0];
        wr_off = {idx[5:0], w[3:0]};
        wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R1", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        lookup("R1", 5, 3, PA, 4'b0000, 32'd0, 1'b0);
        @(negedge clk); #5;
        check("R2", "no request, rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_first_fill;
        fill(5, PA);                                       // lowest free way: 0
        lookup("R3", 5, 3, PA, 4'b0001, pat(PA, 5, 3), 1'b0);
        lookup("R4", 5, 3, PB, 4'b0000, 32'd0, 1'b0);
        lookup("R2", 6, 3, PA, 4'b0000, 32'd0, 1'b0);      // neighbour set empty
        fill(6, PA);
        lookup("R2", 6, 15, PA, 4'b0001, pat(PA, 6, 15), 1'b0);
    endtask

    task automatic t_fill_free_ways;
        fill(5, PB);
        fill(5, PC);
        fill(5, PD);
        lookup("R5", 5, 0, PB, 4'b0010, pat(PB, 5, 0), 1'b0);
        lookup("R5", 5, 7, PC, 4'b0100, pat(PC, 5, 7), 1'b0);
        lookup("R5", 5, 9, PD, 4'b1000, pat(PD, 5, 9), 1'b0);
    endtask

    task automatic t_plru;
        // tree state now root 0, both pair bits 0; a hit on way 0 steers to way 2
        lookup("R6", 5, 1, PA, 4'b0001, pat(PA, 5, 1), 1'b0);
        fill(5, PE);
        lookup("R6", 5, 2, PC, 4'b0000, 32'd0, 1'b0);
        lookup("R6", 5, 2, PE, 4'b0100, pat(PE, 5, 2), 1'b0);
        // hit on way 3 puts root at 0; pair 0/1 bit is 1 so victim is way 1
        lookup("R6", 5, 4, PD, 4'b1000, pat(PD, 5, 4), 1'b0);
        fill(5, PF);
        lookup("R6", 5, 5, PF, 4'b0010, pat(PF, 5, 5), 1'b0);
        lookup("R6", 5, 5, PB, 4'b0000, 32'd0, 1'b0);
        lookup("R6", 5, 6, PA, 4'b0001, pat(PA, 5, 6), 1'b0);
    endtask

    task automatic t_word_write;
        word_write(0, 5, 3, 32'hCAFE_F00D);
        lookup("R7", 5, 3, PA, 4'b0001, 32'hCAFE_F00D, 1'b0);
        lookup("R7", 5, 4, PA, 4'b0001, pat(PA, 5, 4), 1'b0);
        lookup("R7", 5, 3, PE, 4'b0100, pat(PE, 5, 3), 1'b0);
    endtask

    task automatic t_multi_hit;
        fill(9, PG);
        fill(9, PG);                                       // same line lands in way 1
        lookup("R8", 9, 0, PG, 4'b0011, pat(PG, 9, 0), 1'b1);
        lookup("R8", 5, 5, PF, 4'b0010, pat(PF, 5, 5), 1'b0);
    endtask

    task automatic t_invalidate;
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        lookup("R9", 5, 3, PA, 4'b0000, 32'd0, 1'b0);
        lookup("R9", 9, 0, PG, 4'b0000, 32'd0, 1'b0);
        lookup("R9", 6, 15, PA, 4'b0000, 32'd0, 1'b0);
        fill(5, PH);
        lookup("R9", 5, 8, PH, 4'b0001, pat(PH, 5, 8), 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state;
        t_first_fill;
        t_fill_free_ways;
        t_plru;
        t_word_write;
        t_multi_hit;
        t_invalidate;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule